// File: doc/BRIEF.md
# DDR read burst truncation unit

This block models the read data path of one bank of a double-data-rate SDRAM. A read command arms a burst. After a fixed CAS latency the burst's words leave the block two per clock cycle: one word stands for the rising edge and one for the falling edge. A strobe-enable flag marks the cycles in which the strobe is driven. In the cycle just before the first data it also flags a one-cycle preamble. When no flag is raised, the data and the strobe are taken to be high impedance.

A precharge to the bank that owns the burst can end the burst early. The last valid pair then appears CL-1 cycles after the precharge, and the outputs float from CL cycles after it. A precharge that arrives late enough lets the whole burst through. A precharge to any other bank does nothing. Each word carries its index within the burst, so a consumer or a bench can see exactly which word came last. The word values are taken from a pair of source inputs and passed through during data cycles.

Top module: `ddr_rd_trunc`

## Requirements
- R1: After reset, `dq_vld`, `dqs_oe`, `dqs_pre` and `rd_err` are 0, and both data outputs read 0.
- R2: When the block is idle and `cmd` is 2'b01 (read) at a rising edge, it outputs BL/2 data cycles. The first data cycle is the cycle after the edge that lies CL edges after the read edge. In data cycle k (counted from 0), `dq_vld` is 1, `idx_rise` is 2k, `idx_fall` is 2k+1, and `dq_rise`/`dq_fall` equal `src_rise`/`src_fall` of that cycle.
- R3: In the cycle just before the first data cycle, `dqs_pre` and `dqs_oe` are 1 and `dq_vld` is 0. Before that cycle the strobe is not driven.
- R4: A precharge (`cmd` 2'b10) to the burst's bank, sampled p edges after the read with 1 <= p < BL/2, makes the data cycle that starts CL-1 cycles after the precharge the last one. Its `idx_fall` is 2p-1, and `dq_vld` is 0 from CL cycles after the precharge.
- R5: A precharge to the burst's bank sampled p >= BL/2 edges after the read leaves all BL words intact.
- R6: A precharge whose bank differs from the burst's bank has no effect on the burst.
- R7: In every cycle that is neither a data cycle nor the preamble, `dqs_oe` is 0 and both data outputs read 0. This holds straight after a truncated or complete burst as well.
- R8: A read to the burst's bank sampled while a burst is in flight raises `rd_err` for exactly the following cycle. The read is ignored and the running burst continues unchanged.
- R9: A read to another bank sampled while a burst is in flight is ignored and does not raise `rd_err`.
- R10: A precharge while idle, and `cmd` 2'b11, have no effect; outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | 00 idle, 01 read, 10 precharge, 11 idle |
| bank | input | BAW | Bank address for the command |
| src_rise | input | W | Word supplied for the rising-edge slot |
| src_fall | input | W | Word supplied for the falling-edge slot |
| dq_rise | output | W | Rising-edge word, 0 when floating |
| dq_fall | output | W | Falling-edge word, 0 when floating |
| idx_rise | output | IW | Burst index of the rising-edge word |
| idx_fall | output | IW | Burst index of the falling-edge word |
| dq_vld | output | 1 | Data cycle: words are driven and valid |
| dqs_oe | output | 1 | Strobe driven (preamble or data) |
| dqs_pre | output | 1 | Strobe preamble cycle |
| rd_err | output | 1 | Read collided with an in-flight burst |

## Verification
Two events can meet in one cycle: a same-bank precharge lands inside the latency window of the burst it ends, while the natural end of that burst falls in the same cycles. The bench places the precharge at every offset from one edge after the read to past the natural end, once with the matching bank and once with another bank. For each offset it derives the expected last data cycle as the earlier of p+CL-1 and the natural end, and compares validity, indices and float state cycle by cycle. A second read colliding with a running burst is judged the same way: the error pulse must appear while the indices continue undisturbed.

// File: rtl/ddr_rd_trunc.sv
module ddr_rd_trunc #(
  parameter int BL  = 8,
  parameter int CL  = 3,
  parameter int W   = 16,
  parameter int BAW = 2,
  localparam int IW = $clog2(BL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cmd,
  input  logic [BAW-1:0] bank,
  input  logic [W-1:0]   src_rise,
  input  logic [W-1:0]   src_fall,
  output logic [W-1:0]   dq_rise,
  output logic [W-1:0]   dq_fall,
  output logic [IW-1:0]  idx_rise,
  output logic [IW-1:0]  idx_fall,
  output logic           dq_vld,
  output logic           dqs_oe,
  output logic           dqs_pre,
  output logic           rd_err
);
  localparam int NCYC = BL / 2;
  localparam int AW   = $clog2(CL + NCYC + 1) + 1;
  localparam logic [1:0] C_RD = 2'b01;
  localparam logic [1:0] C_PR = 2'b10;
  localparam logic [AW-1:0] NAT_END = AW'(CL + NCYC - 1);

  logic           busy;
  logic [AW-1:0]  age;
  logic [AW-1:0]  last;
  logic [BAW-1:0] bank_q;

  wire hit      = bank == bank_q;
  wire [AW-1:0] cut_at = age + AW'(CL);
  wire in_data  = busy && age >= AW'(CL);
  wire [AW-1:0] pair = age - AW'(CL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      age    <= '0;
      last   <= '0;
      bank_q <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= busy && cmd == C_RD && hit;
      if (busy) begin
        if (age == last) begin
          busy <= 1'b0;
        end else begin
          age <= age + 1'b1;
          if (cmd == C_PR && hit && cut_at < last)
            last <= cut_at;
        end
      end else if (cmd == C_RD) begin
        busy   <= 1'b1;
        age    <= '0;
        bank_q <= bank;
        last   <= NAT_END;
      end
    end
  end

  assign dq_vld   = in_data;
  assign dqs_pre  = busy && age == AW'(CL - 1);
  assign dqs_oe   = in_data || dqs_pre;
  assign dq_rise  = in_data ? src_rise : '0;
  assign dq_fall  = in_data ? src_fall : '0;
  assign idx_rise = in_data ? IW'({pair, 1'b0}) : '0;
  assign idx_fall = in_data ? IW'({pair, 1'b1}) : '0;
endmodule

module ddr_rd_trunc_chk #(
  parameter int BL  = 8,
  parameter int CL  = 3,
  parameter int W   = 16,
  parameter int BAW = 2,
  localparam int IW = $clog2(BL)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cmd,
  input logic [BAW-1:0] bank,
  input logic [BAW-1:0] bank_q,
  input logic           busy,
  input logic [W-1:0]   dq_rise,
  input logic [IW-1:0]  idx_rise,
  input logic           dq_vld,
  input logic           dqs_oe,
  input logic           dqs_pre,
  input logic           rd_err
);
  localparam int CW = $clog2(CL + 2) + 1;
  logic [CW-1:0] pc;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else if (cmd == 2'b10 && busy && bank == bank_q) pc <= CW'(1);
    else if (pc != '0 && pc <= CW'(CL)) pc <= pc + 1'b1;
    else pc <= '0;
  end

  a_r3_pre_then_first: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |=> dq_vld && idx_rise == '0);

  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    dq_vld && $past(dq_vld) |-> idx_rise == IW'($past(idx_rise) + IW'(2)));

  a_r7_float_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_vld) |-> !dqs_oe && dq_rise == '0);

  a_r4_cut_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pc == CW'(CL + 1) |-> !dq_vld);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(cmd) == 2'b01 && $past(busy));
endmodule

bind ddr_rd_trunc ddr_rd_trunc_chk #(.BL(BL), .CL(CL), .W(W), .BAW(BAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .bank_q(bank_q), .busy(busy),
  .dq_rise(dq_rise), .idx_rise(idx_rise), .dq_vld(dq_vld), .dqs_oe(dqs_oe),
  .dqs_pre(dqs_pre), .rd_err(rd_err)
);

// File: tb/ddr_rd_trunc_tb.sv
module ddr_rd_trunc_tb_top;
  localparam int BL = 8, CL = 3, W = 16, BAW = 2, IW = 3, NCYC = BL / 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 2'b00;
  logic [BAW-1:0] bank = '0;
  logic [W-1:0] src_rise = '0, src_fall = '0;
  logic [W-1:0] dq_rise, dq_fall;
  logic [IW-1:0] idx_rise, idx_fall;
  logic dq_vld, dqs_oe, dqs_pre, rd_err;
  int checks = 0, fails = 0;
  bit done = 0;

  ddr_rd_trunc #(.BL(BL), .CL(CL), .W(W), .BAW(BAW)) dut_i (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input int p, input bit psame, input int r2, input bit r2same, input string tag);
    int endc;
    endc = (p > 0 && psame && p < NCYC) ? p + CL - 1 : CL + NCYC - 1;
    @(negedge clk); cmd = 2'b01; bank = 2'd1;
    for (int j = 0; j <= CL + NCYC + 1; j++) begin
      bit ev;
      @(negedge clk);
      src_rise = W'(16'h1100 + j);
      src_fall = W'(16'h2200 + j);
      cmd = 2'b00;
      if (j + 1 == p) begin cmd = 2'b10; bank = psame ? 2'd1 : 2'd2; end
      else if (j + 1 == r2) begin cmd = 2'b01; bank = r2same ? 2'd1 : 2'd2; end
      #1;
      ev = j >= CL && j <= endc;
      chk(dq_vld == ev, tag, dq_vld, ev);
      chk(dqs_pre == (j == CL - 1), "R3 preamble", dqs_pre, j == CL - 1);
      chk(dqs_oe == (ev || j == CL - 1), "R3 strobe enable", dqs_oe, ev || j == CL - 1);
      if (ev) begin
        chk(idx_rise == IW'(2 * (j - CL)), "R2 rise index", idx_rise, 2 * (j - CL));
        chk(idx_fall == IW'(2 * (j - CL) + 1), "R2 fall index", idx_fall, 2 * (j - CL) + 1);
        chk(dq_rise == src_rise && dq_fall == src_fall, "R2 data pass", dq_rise, src_rise);
      end else begin
        chk(dq_rise == '0 && dq_fall == '0, "R7 float", dq_rise, 0);
      end
      if (r2 > 0)
        chk(rd_err == (j == r2 && r2same), r2same ? "R8 error" : "R9 no error", rd_err, j == r2 && r2same);
    end
    cmd = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!dq_vld && !dqs_oe && !dqs_pre && !rd_err && dq_rise == '0, "R1 reset", dq_vld, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 0, 0, "R2 full burst");
    for (int p = 1; p <= NCYC + 2; p++)
      for (int s = 0; s < 2; s++)
        run(p, s[0], 0, 0, (s == 1) ? ((p < NCYC) ? "R4 truncation" : "R5 late precharge") : "R6 other bank");
    run(0, 0, 2, 1, "R8 burst intact");
    run(0, 0, 4, 1, "R8 burst intact");
    run(0, 0, 2, 0, "R9 burst intact");
    run(2, 1, 4, 1, "R4 cut with error");
    @(negedge clk); cmd = 2'b10; bank = 2'd1;
    @(negedge clk); cmd = 2'b11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cmd = 2'b00; #1;
      chk(!dq_vld && !dqs_oe && !dqs_pre && !rd_err, "R10 idle commands", dqs_oe, 0);
    end
    run(0, 0, 0, 0, "R10 later burst full");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule